// File: doc/BRIEF.md
# Queued-Duty Pulse Width Modulator

This block is a register-mapped pulse width modulator. Software programs a period, a clock divider and a clock source, then pushes duty values through a sample register. The values wait in a small queue and each one is taken up only when the running period ends, so a new duty value never cuts a pulse short. The status register reports how many values are waiting. A driver checks it before it pushes, so it can stall instead of overrunning the queue.

Each output period lasts the programmed period value plus two divided clock ticks. The output is active from the start of the period until the counter reaches the current duty value, and it is inactive for the rest of the period. A polarity bit swaps the two levels. The clock source comes in as two single-cycle tick strobes, one for the normal bus clock and one for the fast bus clock. A control field selects which strobe feeds the divider. A self-clearing software reset puts the control fields, the queue and the counter back to idle within a few cycles.

Top module: `pwm_fifo_gen`

## Requirements
- R1: After reset, reads of control (0x00), status (0x04), sample (0x0C) and period (0x10) all return 0. Control fields read back as written: enable in bit 0, divider in bits 15:4, source in bits 17:16, polarity in bit 18, and four plain storage bits in 25:22. All other control bits read as 0.
- R2: One output period lasts (period + 2) divided ticks. The output is active while the in-period counter is below the duty value. A duty of 0 keeps the output inactive, and a duty of period + 2 or more keeps it active.
- R3: A divider field value N makes one divided tick every N+1 ticks of the selected source.
- R4: Source field value 1 selects the normal tick input and value 2 selects the fast tick input. Values 0 and 3 select no source, and the counter then holds its position.
- R5: Control bit 18 set inverts the output, so the active level is low.
- R6: A write to the sample register pushes the value into a four-entry queue, and status bits 2:0 give the number of entries. A write while the queue holds four entries is dropped.
- R7: When enable rises, the oldest queued value becomes the duty value. At each later period end the next queued value is taken, in write order. If the queue is empty, the previous duty value stays in use.
- R8: While enable (bit 0) is clear, the counter holds at zero and the output sits at the level of the polarity bit.
- R9: Writing control bit 3 starts a software reset. Bit 3 reads 1 for SWR_CYCLES cycles and then clears itself. The reset clears every control field, the queue, the counter and the duty value, and keeps the period register. Register writes are ignored while the reset runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe; data appears on bus_rdata the next cycle |
| bus_rdata | output | 32 | Registered read data |
| tick_norm | input | 1 | One-cycle tick from the normal source clock |
| tick_fast | input | 1 | One-cycle tick from the fast source clock |
| pwm_out | output | 1 | Modulated output |

## Verification
The waveform is measured from one active edge to the next. The runs use two period lengths, a divider of one against three, the fast source against the half-rate normal source, and both polarities. A wrong plus-two offset, divider ratio or source choice therefore shows up as a distinct period length. The duty extremes of zero and period plus two are checked by counting levels over a window. This separates a saturating compare from an off-by-one compare. A queue test loads four distinct duty values plus one extra that must be dropped. Per-period high times then show the write order, the boundary at which each value is taken and the reuse of the last value.

// File: rtl/pwm_fifo_pkg.sv
package pwm_fifo_pkg;

    // Register byte offsets
    localparam int OFS_CTRL   = 0;
    localparam int OFS_STAT   = 4;
    localparam int OFS_SAMPLE = 12;
    localparam int OFS_PERIOD = 16;

    // Control bit positions
    localparam int B_EN     = 0;
    localparam int B_SWR    = 3;
    localparam int B_PSC_LO = 4;
    localparam int PSC_W    = 12;
    localparam int B_SEL_LO = 16;
    localparam int B_POL    = 18;
    localparam int B_DBG    = 22;
    localparam int B_WAIT   = 23;
    localparam int B_DOZE   = 24;
    localparam int B_STOP   = 25;

    typedef enum logic [1:0] {
        SRC_NONE = 2'd0,
        SRC_NORM = 2'd1,
        SRC_FAST = 2'd2,
        SRC_RSVD = 2'd3
    } clk_src_e;

    typedef struct packed {
        logic             stop_en;
        logic             doze_en;
        logic             wait_en;
        logic             dbg_en;
        logic             pol;
        clk_src_e         src;
        logic [PSC_W-1:0] psc;
        logic             swr;
        logic             en;
    } ctrl_t;

endpackage

// File: rtl/pwm_regs.sv
module pwm_regs
    import pwm_fifo_pkg::*;
#(
    parameter int ADDR_W     = 5,
    parameter int PERIOD_W   = 16,
    parameter int CNT_W      = 3,
    parameter int SWR_CYCLES = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [31:0]         bus_wdata,
    input  logic                bus_wr,
    input  logic                bus_rd,
    output logic [31:0]         bus_rdata,
    input  logic [CNT_W-1:0]    fifo_count,
    input  logic [PERIOD_W-1:0] duty_act,
    output ctrl_t               ctrl,
    output logic [PERIOD_W-1:0] period,
    output logic                push,
    output logic [PERIOD_W-1:0] push_data
);

    localparam int SWRC_W = $clog2(SWR_CYCLES + 1);

    typedef struct packed {
        ctrl_t               ctrl;
        logic [PERIOD_W-1:0] period;
        logic [SWRC_W-1:0]   swr_cnt;
        logic [31:0]         rdata;
    } reg_state_t;

    reg_state_t st_d, st_q;

    logic sel_ctrl, sel_stat, sel_sample, sel_period;

    always_comb begin
        sel_ctrl   = (bus_addr == ADDR_W'(OFS_CTRL));
        sel_stat   = (bus_addr == ADDR_W'(OFS_STAT));
        sel_sample = (bus_addr == ADDR_W'(OFS_SAMPLE));
        sel_period = (bus_addr == ADDR_W'(OFS_PERIOD));
    end

    always_comb begin
        st_d = st_q;
        if (st_q.ctrl.swr) begin
            if (st_q.swr_cnt == '0) begin
                st_d.ctrl.swr = 1'b0;
            end else begin
                st_d.swr_cnt = st_q.swr_cnt - SWRC_W'(1);
            end
        end else if (bus_wr) begin
            if (sel_ctrl) begin
                if (bus_wdata[B_SWR]) begin
                    st_d.ctrl     = '0;
                    st_d.ctrl.swr = 1'b1;
                    st_d.swr_cnt  = SWRC_W'(SWR_CYCLES - 1);
                end else begin
                    st_d.ctrl.en      = bus_wdata[B_EN];
                    st_d.ctrl.swr     = 1'b0;
                    st_d.ctrl.psc     = bus_wdata[B_PSC_LO +: PSC_W];
                    st_d.ctrl.src     = clk_src_e'(bus_wdata[B_SEL_LO +: 2]);
                    st_d.ctrl.pol     = bus_wdata[B_POL];
                    st_d.ctrl.dbg_en  = bus_wdata[B_DBG];
                    st_d.ctrl.wait_en = bus_wdata[B_WAIT];
                    st_d.ctrl.doze_en = bus_wdata[B_DOZE];
                    st_d.ctrl.stop_en = bus_wdata[B_STOP];
                end
            end else if (sel_period) begin
                st_d.period = bus_wdata[PERIOD_W-1:0];
            end
        end

        if (bus_rd) begin
            st_d.rdata = '0;
            if (sel_ctrl) begin
                st_d.rdata[B_EN]               = st_q.ctrl.en;
                st_d.rdata[B_SWR]              = st_q.ctrl.swr;
                st_d.rdata[B_PSC_LO +: PSC_W]  = st_q.ctrl.psc;
                st_d.rdata[B_SEL_LO +: 2]      = st_q.ctrl.src;
                st_d.rdata[B_POL]              = st_q.ctrl.pol;
                st_d.rdata[B_DBG]              = st_q.ctrl.dbg_en;
                st_d.rdata[B_WAIT]             = st_q.ctrl.wait_en;
                st_d.rdata[B_DOZE]             = st_q.ctrl.doze_en;
                st_d.rdata[B_STOP]             = st_q.ctrl.stop_en;
            end else if (sel_stat) begin
                st_d.rdata[CNT_W-1:0] = fifo_count;
            end else if (sel_sample) begin
                st_d.rdata[PERIOD_W-1:0] = duty_act;
            end else if (sel_period) begin
                st_d.rdata[PERIOD_W-1:0] = st_q.period;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign bus_rdata = st_q.rdata;
    assign ctrl      = st_q.ctrl;
    assign period    = st_q.period;
    assign push      = bus_wr && sel_sample && !st_q.ctrl.swr;
    assign push_data = bus_wdata[PERIOD_W-1:0];

    // R9: the reset window counter never exceeds its configured length
    p_swr_window_r9: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.ctrl.swr |-> (int'(st_q.swr_cnt) < SWR_CYCLES))
        else $error("reset window counter out of range");

    // R9: starting a reset leaves the counter disabled and the divider cleared
    p_swr_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.ctrl.swr) |-> (!st_q.ctrl.en && st_q.ctrl.psc == '0))
        else $error("control fields survived software reset");

endmodule

// File: rtl/pwm_sample_fifo.sv
module pwm_sample_fifo #(
    parameter int DEPTH  = 4,
    parameter int DATA_W = 16,
    parameter int CNT_W  = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              push,
    input  logic [DATA_W-1:0] push_data,
    input  logic              pop,
    output logic [DATA_W-1:0] head,
    output logic [CNT_W-1:0]  count,
    output logic              empty
);

    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    typedef struct packed {
        logic [DEPTH-1:0][DATA_W-1:0] mem;
        logic [PTR_W-1:0]             wr_ptr;
        logic [PTR_W-1:0]             rd_ptr;
        logic [CNT_W-1:0]             count;
    } fifo_state_t;

    fifo_state_t st_d, st_q;
    logic do_push, do_pop;

    function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
        if (int'(p) == DEPTH - 1) return '0;
        return p + PTR_W'(1);
    endfunction

    always_comb begin
        do_push = push && (int'(st_q.count) < DEPTH);
        do_pop  = pop && (st_q.count != '0);
        st_d    = st_q;
        if (flush) begin
            st_d.wr_ptr = '0;
            st_d.rd_ptr = '0;
            st_d.count  = '0;
        end else begin
            if (do_push) begin
                st_d.mem[st_q.wr_ptr] = push_data;
                st_d.wr_ptr           = ptr_inc(st_q.wr_ptr);
            end
            if (do_pop) begin
                st_d.rd_ptr = ptr_inc(st_q.rd_ptr);
            end
            case ({do_push, do_pop})
                2'b10:   st_d.count = st_q.count + CNT_W'(1);
                2'b01:   st_d.count = st_q.count - CNT_W'(1);
                default: st_d.count = st_q.count;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign head  = st_q.mem[st_q.rd_ptr];
    assign count = st_q.count;
    assign empty = (st_q.count == '0);

    // R6: occupancy never exceeds the queue depth
    p_count_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
        int'(st_q.count) <= DEPTH)
        else $error("queue occupancy above depth");

    // R6: a push into a full queue without a pop is dropped
    p_full_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (push && int'(st_q.count) == DEPTH && !pop && !flush) |=> $stable(st_q.count))
        else $error("push into full queue changed occupancy");

    // R9: a flush leaves the queue empty
    p_flush_empty_r9: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (st_q.count == '0))
        else $error("queue not empty after flush");

endmodule

// File: rtl/pwm_prescaler.sv
module pwm_prescaler
    import pwm_fifo_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             clear,
    input  clk_src_e         src,
    input  logic [PSC_W-1:0] psc,
    input  logic             tick_norm,
    input  logic             tick_fast,
    output logic             pulse
);

    typedef struct packed {
        logic [PSC_W-1:0] div;
    } psc_state_t;

    psc_state_t st_d, st_q;
    logic src_tick;

    always_comb begin
        case (src)
            SRC_NORM: src_tick = tick_norm;
            SRC_FAST: src_tick = tick_fast;
            default:  src_tick = 1'b0;
        endcase
        pulse = en && !clear && src_tick && (st_q.div >= psc);
        st_d  = st_q;
        if (!en || clear) begin
            st_d.div = '0;
        end else if (src_tick) begin
            st_d.div = (st_q.div >= psc) ? '0 : st_q.div + PSC_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R4: with no source selected the divider does not move
    p_div_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !clear && src == SRC_NONE) |=> $stable(st_q.div))
        else $error("divider advanced without a source");

endmodule

// File: rtl/pwm_counter.sv
module pwm_counter #(
    parameter int PERIOD_W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                en,
    input  logic                pol,
    input  logic                clear,
    input  logic                pulse,
    input  logic [PERIOD_W-1:0] period,
    input  logic [PERIOD_W-1:0] head,
    input  logic                fifo_empty,
    output logic                pop,
    output logic [PERIOD_W-1:0] duty_act,
    output logic                pwm_out
);

    localparam int CNT_W = PERIOD_W + 1;

    typedef struct packed {
        logic [CNT_W-1:0]    cnt;
        logic [PERIOD_W-1:0] duty;
        logic                en_prev;
    } cnt_state_t;

    cnt_state_t st_d, st_q;
    logic start, last;

    always_comb begin
        start = en && !st_q.en_prev;
        last  = st_q.cnt >= ({1'b0, period} + CNT_W'(1));
        pop   = !clear && !fifo_empty && (start || (en && pulse && last));
        st_d  = st_q;
        if (clear) begin
            st_d = '0;
        end else begin
            st_d.en_prev = en;
            if (!en) begin
                st_d.cnt = '0;
            end else if (pulse) begin
                st_d.cnt = last ? '0 : st_q.cnt + CNT_W'(1);
            end
            if (pop) begin
                st_d.duty = head;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign duty_act = st_q.duty;
    assign pwm_out  = pol ^ (en && (st_q.cnt < {1'b0, st_q.duty}));

    // R8: a disabled counter is back at zero on the next cycle
    p_idle_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (st_q.cnt == '0))
        else $error("counter moved while disabled");

    // R7: the duty value only changes on a pop or a reset
    p_duty_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!pop && !clear) |=> $stable(st_q.duty))
        else $error("duty changed without a queue pop");

endmodule

// File: rtl/pwm_fifo_gen.sv
module pwm_fifo_gen
    import pwm_fifo_pkg::*;
#(
    parameter int ADDR_W     = 5,
    parameter int PERIOD_W   = 16,
    parameter int FIFO_DEPTH = 4,
    parameter int SWR_CYCLES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    input  logic              bus_wr,
    input  logic              bus_rd,
    output logic [31:0]       bus_rdata,
    input  logic              tick_norm,
    input  logic              tick_fast,
    output logic              pwm_out
);

    localparam int CNT_W = $clog2(FIFO_DEPTH + 1);

    ctrl_t               ctrl;
    logic [PERIOD_W-1:0] period;
    logic                push;
    logic [PERIOD_W-1:0] push_data;
    logic [CNT_W-1:0]    fifo_count;
    logic [PERIOD_W-1:0] head;
    logic                fifo_empty;
    logic                pop;
    logic [PERIOD_W-1:0] duty_act;
    logic                pulse;

    pwm_regs #(
        .ADDR_W    (ADDR_W),
        .PERIOD_W  (PERIOD_W),
        .CNT_W     (CNT_W),
        .SWR_CYCLES(SWR_CYCLES)
    ) regs_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_rdata (bus_rdata),
        .fifo_count(fifo_count),
        .duty_act  (duty_act),
        .ctrl      (ctrl),
        .period    (period),
        .push      (push),
        .push_data (push_data)
    );

    pwm_sample_fifo #(
        .DEPTH (FIFO_DEPTH),
        .DATA_W(PERIOD_W),
        .CNT_W (CNT_W)
    ) fifo_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .flush    (ctrl.swr),
        .push     (push),
        .push_data(push_data),
        .pop      (pop),
        .head     (head),
        .count    (fifo_count),
        .empty    (fifo_empty)
    );

    pwm_prescaler psc_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (ctrl.en),
        .clear    (ctrl.swr),
        .src      (ctrl.src),
        .psc      (ctrl.psc),
        .tick_norm(tick_norm),
        .tick_fast(tick_fast),
        .pulse    (pulse)
    );

    pwm_counter #(
        .PERIOD_W(PERIOD_W)
    ) cnt_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (ctrl.en),
        .pol       (ctrl.pol),
        .clear     (ctrl.swr),
        .pulse     (pulse),
        .period    (period),
        .head      (head),
        .fifo_empty(fifo_empty),
        .pop       (pop),
        .duty_act  (duty_act),
        .pwm_out   (pwm_out)
    );

endmodule

// File: tb/pwm_fifo_gen_tb_top.sv
module pwm_fifo_gen_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W     = 5;
    localparam int SWR_CYCLES = 4;
    localparam int WDOG_LIMIT = 100000;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [31:0]       bus_wdata = '0;
    logic              bus_wr = 1'b0;
    logic              bus_rd = 1'b0;
    logic [31:0]       bus_rdata;
    logic              tick_norm = 1'b0;
    logic              tick_fast = 1'b1;
    logic              pwm_out;

    int n_checks = 0;
    int n_fail   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(negedge clk) tick_norm <= ~tick_norm;

    pwm_fifo_gen #(
        .ADDR_W    (ADDR_W),
        .SWR_CYCLES(SWR_CYCLES)
    ) dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_addr (bus_addr),
        .bus_wdata(bus_wdata),
        .bus_wr   (bus_wr),
        .bus_rd   (bus_rd),
        .bus_rdata(bus_rdata),
        .tick_norm(tick_norm),
        .tick_fast(tick_fast),
        .pwm_out  (pwm_out)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FIFO_GEN FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic reg_wr(input int addr, input logic [31:0] data);
        @(negedge clk);
        bus_addr  = ADDR_W'(addr);
        bus_wdata = data;
        bus_wr    = 1'b1;
        @(negedge clk);
        bus_wr    = 1'b0;
    endtask

    task automatic reg_rd(input int addr, output logic [31:0] data);
        @(negedge clk);
        bus_addr = ADDR_W'(addr);
        bus_rd   = 1'b1;
        @(negedge clk);
        bus_rd   = 1'b0;
        data     = bus_rdata;
    endtask

    task automatic soft_reset();
        reg_wr(0, 32'h8);
        repeat (SWR_CYCLES + 2) @(negedge clk);
    endtask

    function automatic logic [31:0] ctrl_word(input int en, input int psc,
                                              input int sel, input int pol);
        return 32'(en) | (32'(psc) << 4) | (32'(sel) << 16) | (32'(pol) << 18);
    endfunction

    // Wait for the output to reach the active level after being elsewhere
    task automatic wait_edge(input logic lvl, output bit ok);
        logic prev;
        ok   = 1'b0;
        prev = pwm_out;
        for (int i = 0; i < 1000; i++) begin
            @(negedge clk);
            if (prev != lvl && pwm_out == lvl) begin
                ok = 1'b1;
                break;
            end
            prev = pwm_out;
        end
    endtask

    // Starting on an active edge: cycles to the next edge and active cycles in between
    task automatic measure(input logic lvl, output int per, output int act);
        logic prev;
        per  = 1;
        act  = 1;
        prev = pwm_out;
        for (int i = 0; i < 1000; i++) begin
            @(negedge clk);
            if (prev != lvl && pwm_out == lvl) break;
            per++;
            if (pwm_out == lvl) act++;
            prev = pwm_out;
        end
    endtask

    task automatic count_high(input int n, output int hi);
        hi = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (pwm_out) hi++;
        end
    endtask

    task automatic t_reset_values();
        logic [31:0] d;
        reg_rd(0, d);  chk("R1 control after reset", int'(d), 0);
        reg_rd(4, d);  chk("R1 status after reset", int'(d), 0);
        reg_rd(12, d); chk("R1 sample after reset", int'(d), 0);
        reg_rd(16, d); chk("R1 period after reset", int'(d), 0);
    endtask

    task automatic t_readback();
        logic [31:0] d;
        // storage bits 25:22, polarity, source 2, divider 0x5A, bits 2:1 undefined
        reg_wr(0, 32'h03C6_05A6);
        reg_rd(0, d);  chk("R1 control readback", int'(d), 32'h03C6_05A0);
        reg_wr(16, 32'h0000_1234);
        reg_rd(16, d); chk("R1 period readback", int'(d), 32'h1234);
        soft_reset();
    endtask

    task automatic t_wave(input string tag, input int psc, input int sel, input int pol,
                          input int per_v, input int duty, input int exp_per, input int exp_act);
        bit ok;
        int per, act;
        logic lvl;
        lvl = (pol != 0) ? 1'b0 : 1'b1;
        soft_reset();
        reg_wr(12, 32'(duty));
        reg_wr(16, 32'(per_v));
        reg_wr(0, ctrl_word(1, psc, sel, pol));
        wait_edge(lvl, ok);
        chk({tag, " first edge"}, int'(ok), 1);
        wait_edge(lvl, ok);
        measure(lvl, per, act);
        chk({tag, " period"}, per, exp_per);
        chk({tag, " active"}, act, exp_act);
    endtask

    task automatic t_const();
        int hi;
        soft_reset();
        reg_wr(12, 0); reg_wr(16, 6); reg_wr(0, ctrl_word(1, 0, 2, 0));
        repeat (5) @(negedge clk);
        count_high(40, hi);
        chk("R2 duty zero stays low", hi, 0);
        soft_reset();
        reg_wr(12, 8); reg_wr(16, 6); reg_wr(0, ctrl_word(1, 0, 2, 0));
        repeat (5) @(negedge clk);
        count_high(40, hi);
        chk("R2 duty period+2 stays high", hi, 40);
    endtask

    task automatic t_halt();
        int hi;
        soft_reset();
        reg_wr(12, 3); reg_wr(16, 6); reg_wr(0, ctrl_word(1, 0, 0, 0));
        repeat (5) @(negedge clk);
        count_high(40, hi);
        chk("R4 no source halts counter", hi, 40);
    endtask

    task automatic t_fifo();
        logic [31:0] d;
        bit ok;
        int per, act;
        soft_reset();
        reg_wr(12, 2); reg_wr(12, 3); reg_wr(12, 4); reg_wr(12, 5);
        reg_rd(4, d);  chk("R6 status full", int'(d), 4);
        reg_wr(12, 6);
        reg_rd(4, d);  chk("R6 status after dropped write", int'(d), 4);
        reg_wr(16, 6);
        reg_wr(0, ctrl_word(1, 0, 2, 0));
        wait_edge(1'b1, ok);
        chk("R7 first edge", int'(ok), 1);
        wait_edge(1'b1, ok);
        measure(1'b1, per, act); chk("R7 second value", act, 3);
        measure(1'b1, per, act); chk("R7 third value", act, 4);
        measure(1'b1, per, act); chk("R7 fourth value", act, 5);
        measure(1'b1, per, act); chk("R7 empty reuses last (R6 drop)", act, 5);
        chk("R7 period unchanged", per, 8);
        reg_rd(4, d);  chk("R6 status drained", int'(d), 0);
        reg_rd(12, d); chk("R7 sample shows active duty", int'(d), 5);
    endtask

    task automatic t_disable();
        int hi;
        soft_reset();
        reg_wr(12, 3); reg_wr(16, 6); reg_wr(0, ctrl_word(1, 0, 2, 0));
        repeat (20) @(negedge clk);
        reg_wr(0, ctrl_word(0, 0, 2, 0));
        count_high(30, hi);
        chk("R8 disabled output low", hi, 0);
        reg_wr(0, ctrl_word(0, 0, 2, 1));
        count_high(30, hi);
        chk("R8 disabled inverted output high", hi, 30);
    endtask

    task automatic t_swr();
        logic [31:0] d;
        soft_reset();
        reg_wr(16, 9);
        reg_wr(12, 7); reg_wr(12, 7);
        reg_wr(0, ctrl_word(0, 3, 1, 1));
        reg_wr(0, 32'h8);
        reg_rd(0, d);  chk("R9 reset bit set, fields clear", int'(d), 32'h8);
        reg_wr(16, 3);
        repeat (SWR_CYCLES + 2) @(negedge clk);
        reg_rd(0, d);  chk("R9 reset bit self-clears", int'(d), 0);
        reg_rd(4, d);  chk("R9 queue flushed", int'(d), 0);
        reg_rd(16, d); chk("R9 period kept, write ignored", int'(d), 9);
        chk("R9 output idle", int'(pwm_out), 0);
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        repeat (WDOG_LIMIT) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FIFO_GEN FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset_values();
        t_readback();
        t_wave("R2 basic",          0, 2, 0, 6, 3, 8, 3);
        t_wave("R2 short period",   0, 2, 0, 4, 1, 6, 1);
        t_wave("R3 divide by three", 2, 2, 0, 6, 3, 24, 9);
        t_wave("R4 normal source",  0, 1, 0, 6, 3, 16, 6);
        t_wave("R5 inverted",       0, 2, 1, 6, 3, 8, 3);
        t_const();
        t_halt();
        t_fifo();
        t_disable();
        t_swr();
        finish_run();
    end

endmodule